// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds stores between address generation and their write into the data cache. Stores are kept in program order in a small circular array. Each slot carries a status, a word address and a data word. A store is written into the buffer once its address is known. Its data may come with it, or it may arrive later through a separate write port that names the slot. Commits are applied to the stores in program order. The oldest committed store is then offered to the cache write port through a valid/ready handshake, and its slot becomes free again.

Loads enter address generation in program order with the stores. This means every store in the buffer is older than a load that probes it. A probe compares the load's word address against every occupied slot, and the youngest matching store decides the result. If nothing matches, the load bypasses the buffer and goes to the cache. If the match is still waiting for its data, the load must be aborted and replayed. If the match has its data, whether committed or not, that data is forwarded to the load. Only aligned full-word accesses are handled, so matching is by exact address.

Top module: `store_buffer`

## Requirements
- R1: After reset every slot is free: `empty`=1, `full`=0, `alloc_ready`=1, `commit_ready`=0 and `drain_valid`=0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. The slot it takes is shown on `alloc_slot` in that same cycle, and successive accepted allocations take slots 0,1,...,DEPTH-1,0,... in turn. The new store waits for data if `alloc_has_data`=0, and holds `alloc_data` if `alloc_has_data`=1.
- R3: `full` is 1 exactly when all DEPTH slots are occupied, and `alloc_ready` equals the inverse of `full`. An allocation offered while the buffer is full changes nothing: no later probe can see it.
- R4: A data write (`wdata_valid`) to a slot whose store is waiting for data stores `wdata_value` and makes that store ready. A data write to a slot in any other status has no effect.
- R5: `commit_ready` is 1 exactly when the oldest uncommitted store has its data. A commit (`commit_valid` and `commit_ready` both high) marks that store committed, so commits follow program order.
- R6: `drain_valid` is 1 exactly when the oldest occupied slot is committed. While it is high, `drain_addr` and `drain_data` show that store and stay stable until `drain_ready` is high. On the handshake the slot is freed. `empty` is 1 when no slot is occupied.
- R7: `probe_outcome` = 2'b00 (bypass) when `probe_valid` is low, or when no occupied slot holds `probe_addr`. `probe_data` is then 0.
- R8: `probe_outcome` = 2'b01 (abort) when the youngest occupied slot matching `probe_addr` is still waiting for data.
- R9: `probe_outcome` = 2'b10 (forward) when the youngest matching slot has data, committed or not. `probe_data` then equals that slot's data.
- R10: When several occupied slots match, only the youngest one decides the outcome and the data.
- R11: A probe sees the buffer as it was at the start of the cycle. An allocation or data write in the same cycle does not affect that probe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Store address ready to enter |
| alloc_ready | output | 1 | A free slot exists |
| alloc_addr | input | AW | Word address of the store |
| alloc_has_data | input | 1 | Store data known at entry |
| alloc_data | input | DW | Store data when known |
| alloc_slot | output | IW | Slot the next allocation takes |
| wdata_valid | input | 1 | Late store data valid |
| wdata_slot | input | IW | Slot receiving late data |
| wdata_value | input | DW | Late store data |
| commit_valid | input | 1 | Commit the oldest uncommitted store |
| commit_ready | output | 1 | Oldest uncommitted store has data |
| drain_valid | output | 1 | Oldest store committed, offered to cache |
| drain_ready | input | 1 | Cache accepts the write |
| drain_addr | output | AW | Address of the store being drained |
| drain_data | output | DW | Data of the store being drained |
| probe_valid | input | 1 | Load address probe |
| probe_addr | input | AW | Load word address |
| probe_outcome | output | 2 | 00 bypass, 01 abort, 10 forward |
| probe_data | output | DW | Forwarded data |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
A slot left in the wrong status shows up on the probe port in the same cycle. An address that should match gives bypass instead of abort, or abort instead of forward. The bench therefore sweeps every probe address after each operation. A commit or drain pointer that is off by one shows within a cycle as a wrong `commit_ready`, a wrong `drain_valid`, or the wrong store on `drain_addr`/`drain_data`. An occupancy count that disagrees with the slots shows on `full`, `empty` and `alloc_slot` at the next allocation.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_READY = 2'd2,
    ST_CMT   = 2'd3
  } slot_st_e;

  localparam logic [1:0] PR_BYPASS = 2'b00;
  localparam logic [1:0] PR_ABORT  = 2'b01;
  localparam logic [1:0] PR_FWD    = 2'b10;

  // slot reached by stepping off positions forward from base on a ring
  function automatic int ring_slot(int base, int off, int depth);
    return (base + off) % depth;
  endfunction

  // result of a probe given whether anything matched and the youngest match
  function automatic logic [1:0] probe_code(logic found, slot_st_e st);
    if (!found)                           return PR_BYPASS;
    else if (st == ST_ADDR)               return PR_ABORT;
    else if (st == ST_READY || st == ST_CMT) return PR_FWD;
    else                                  return PR_BYPASS;
  endfunction

endpackage

// File: rtl/sb_slot.sv
module sb_slot #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  logic             alloc_has_data,
  input  logic [AW-1:0]    alloc_addr,
  input  logic [DW-1:0]    alloc_data,
  input  logic             wr_hit,
  input  logic [DW-1:0]    wr_data,
  input  logic             commit_hit,
  input  logic             drain_hit,
  output sb_pkg::slot_st_e st,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    data
);
  import sb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_FREE;
      addr <= '0;
      data <= '0;
    end else if (drain_hit) begin
      st <= ST_FREE;
    end else if (alloc_hit) begin
      st   <= alloc_has_data ? ST_READY : ST_ADDR;
      addr <= alloc_addr;
      data <= alloc_has_data ? alloc_data : '0;
    end else if (wr_hit && st == ST_ADDR) begin
      st   <= ST_READY;
      data <= wr_data;
    end else if (commit_hit && st == ST_READY) begin
      st <= ST_CMT;
    end
  end

  // R4
  ad_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ADDR |=> (st == ST_ADDR || st == ST_READY));

  // R6
  cmt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_CMT |=> (st == ST_CMT || st == ST_FREE));

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READY && !commit_hit) |=> (st == ST_READY && $stable(data)));

endmodule

// File: rtl/sb_ring.sv
module sb_ring #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          commit_fire,
  input  logic          drain_fire,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [IW-1:0] cmt,
  output logic [CW-1:0] count
);
  import sb_pkg::*;

  function automatic logic [IW-1:0] step(logic [IW-1:0] p);
    return IW'(ring_slot(int'(p), 1, DEPTH));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cmt   <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= step(tail);
      if (commit_fire) cmt  <= step(cmt);
      if (drain_fire)  head <= step(head);
      if (alloc_fire && !drain_fire)      count <= count + 1'b1;
      else if (!alloc_fire && drain_fire) count <= count - 1'b1;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/sb_probe.sv
module sb_probe #(
  parameter int DEPTH = 4,
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IW-1:0]            head,
  input  logic [DEPTH-1:0][1:0]    slot_st,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic                     probe_valid,
  input  logic [AW-1:0]            probe_addr,
  output logic [1:0]               outcome,
  output logic [DW-1:0]            data
);
  import sb_pkg::*;

  logic            found;
  slot_st_e        hit_st;
  logic [DW-1:0]   hit_data;
  logic [IW-1:0]   idx;

  // walk from oldest to youngest; the last match seen is the youngest
  always_comb begin
    found    = 1'b0;
    hit_st   = ST_FREE;
    hit_data = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = IW'(ring_slot(int'(head), k, DEPTH));
      if (slot_st[idx] != ST_FREE && slot_addr[idx] == probe_addr) begin
        found    = 1'b1;
        hit_st   = slot_st_e'(slot_st[idx]);
        hit_data = slot_data[idx];
      end
    end
    outcome = probe_valid ? probe_code(found, hit_st) : PR_BYPASS;
    data    = (outcome == PR_FWD) ? hit_data : '0;
  end

endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int DEPTH = 4,
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [AW-1:0] alloc_addr,
  input  logic          alloc_has_data,
  input  logic [DW-1:0] alloc_data,
  output logic [IW-1:0] alloc_slot,
  input  logic          wdata_valid,
  input  logic [IW-1:0] wdata_slot,
  input  logic [DW-1:0] wdata_value,
  input  logic          commit_valid,
  output logic          commit_ready,
  output logic          drain_valid,
  input  logic          drain_ready,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data,
  input  logic          probe_valid,
  input  logic [AW-1:0] probe_addr,
  output logic [1:0]    probe_outcome,
  output logic [DW-1:0] probe_data,
  output logic          full,
  output logic          empty
);
  import sb_pkg::*;

  logic [IW-1:0]            head_ptr, tail_ptr, cmt_ptr;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0][1:0]    slot_st;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [DEPTH-1:0]         busy;

  // named internal events
  logic alloc_fire, commit_fire, drain_fire;

  assign full         = (count == CW'(DEPTH));
  assign empty        = (count == '0);
  assign alloc_ready  = !full;
  assign alloc_slot   = tail_ptr;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign commit_ready = (slot_st[cmt_ptr] == ST_READY);
  assign commit_fire  = commit_valid && commit_ready;
  assign drain_valid  = (slot_st[head_ptr] == ST_CMT);
  assign drain_fire   = drain_valid && drain_ready;
  assign drain_addr   = slot_addr[head_ptr];
  assign drain_data   = slot_data[head_ptr];

  sb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .commit_fire(commit_fire), .drain_fire(drain_fire),
    .head(head_ptr), .tail(tail_ptr), .cmt(cmt_ptr), .count(count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_st_e st_i;
    sb_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_hit(alloc_fire && tail_ptr == IW'(i)),
      .alloc_has_data(alloc_has_data),
      .alloc_addr(alloc_addr),
      .alloc_data(alloc_data),
      .wr_hit(wdata_valid && wdata_slot == IW'(i)),
      .wr_data(wdata_value),
      .commit_hit(commit_fire && cmt_ptr == IW'(i)),
      .drain_hit(drain_fire && head_ptr == IW'(i)),
      .st(st_i),
      .addr(slot_addr[i]),
      .data(slot_data[i])
    );
    assign slot_st[i] = st_i;
    assign busy[i]    = (st_i != ST_FREE);
  end

  sb_probe #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_probe (
    .head(head_ptr), .slot_st(slot_st), .slot_addr(slot_addr), .slot_data(slot_data),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .outcome(probe_outcome), .data(probe_data)
  );

  // R3
  occ_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy) == int'(count));

  // R5
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> slot_st[$past(cmt_ptr)] == ST_CMT);

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=>
      (drain_valid && $stable(drain_addr) && $stable(drain_data)));

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!drain_valid && !commit_ready));

  // R7
  outcome_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_outcome) && (probe_valid || probe_outcome == PR_BYPASS));

endmodule

// File: tb/store_buffer_tb.sv
`timescale 1ns/1ps
module store_buffer_tb;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_has_data = 0;
  logic [7:0] alloc_addr = 0;
  logic [15:0] alloc_data = 0;
  logic alloc_ready;
  logic [1:0] alloc_slot;
  logic wdata_valid = 0;
  logic [1:0] wdata_slot = 0;
  logic [15:0] wdata_value = 0;
  logic commit_valid = 0, commit_ready;
  logic drain_valid, drain_ready = 0;
  logic [7:0] drain_addr;
  logic [15:0] drain_data;
  logic probe_valid = 0;
  logic [7:0] probe_addr = 0;
  logic [1:0] probe_outcome;
  logic [15:0] probe_data;
  logic full, empty;

  store_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_addr(alloc_addr),
    .alloc_has_data(alloc_has_data), .alloc_data(alloc_data), .alloc_slot(alloc_slot),
    .wdata_valid(wdata_valid), .wdata_slot(wdata_slot), .wdata_value(wdata_value),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .probe_outcome(probe_outcome), .probe_data(probe_data),
    .full(full), .empty(empty)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // model: status 0 free, 1 waiting data, 2 ready, 3 committed
  int mst[D], maddr[D], mdata[D];
  int mhead = 0, mtail = 0, mcnt = 0, mcmt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic status_chk();
    chk("R3 full", full, mcnt == D);
    chk("R3 alloc_ready", alloc_ready, mcnt < D);
    chk("R6 empty", empty, mcnt == 0);
    chk("R2 alloc_slot", alloc_slot, mtail);
    chk("R5 commit_ready", commit_ready, mst[mcmt] == 2);
    chk("R6 drain_valid", drain_valid, mst[mhead] == 3);
    if (mst[mhead] == 3) begin
      chk("R6 drain_addr", drain_addr, maddr[mhead]);
      chk("R6 drain_data", drain_data, mdata[mhead]);
    end
  endtask

  task automatic probe_chk(int a);
    int found, st, d;
    @(negedge clk);
    probe_valid = 1; probe_addr = 8'(a);
    #1;
    found = 0; st = 0; d = 0;
    for (int k = 0; k < mcnt; k++) begin
      int ix = (mhead + k) % D;
      if (maddr[ix] == a) begin found = 1; st = mst[ix]; d = mdata[ix]; end
    end
    if (!found) begin
      chk("R7 bypass outcome", probe_outcome, 0);
      chk("R7 bypass data", probe_data, 0);
    end else if (st == 1) begin
      chk("R8 R10 abort outcome", probe_outcome, 1);
    end else begin
      chk("R9 R10 forward outcome", probe_outcome, 2);
      chk("R9 R10 forward data", probe_data, d);
    end
    probe_valid = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 6; a++) probe_chk(a);
    @(negedge clk); #1; status_chk();
  endtask

  task automatic alloc_op(int a, int has, int d);
    @(negedge clk);
    alloc_valid = 1; alloc_addr = 8'(a); alloc_has_data = has[0]; alloc_data = 16'(d);
    @(posedge clk);
    if (mcnt < D) begin
      mst[mtail] = has ? 2 : 1; maddr[mtail] = a; mdata[mtail] = has ? d : 0;
      mtail = (mtail + 1) % D; mcnt++;
    end
    #1 alloc_valid = 0;
  endtask

  task automatic wr_op(int s, int d);
    @(negedge clk);
    wdata_valid = 1; wdata_slot = 2'(s); wdata_value = 16'(d);
    @(posedge clk);
    if (mst[s] == 1) begin mst[s] = 2; mdata[s] = d; end
    #1 wdata_valid = 0;
  endtask

  task automatic commit_op();
    @(negedge clk);
    commit_valid = 1;
    @(posedge clk);
    if (mst[mcmt] == 2) begin mst[mcmt] = 3; mcmt = (mcmt + 1) % D; end
    #1 commit_valid = 0;
  endtask

  task automatic drain_op();
    @(negedge clk);
    drain_ready = 1;
    @(posedge clk);
    if (mst[mhead] == 3) begin mst[mhead] = 0; mhead = (mhead + 1) % D; mcnt--; end
    #1 drain_ready = 0;
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin mst[i] = 0; maddr[i] = 0; mdata[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 commit_ready", commit_ready, 0);
    chk("R1 drain_valid", drain_valid, 0);
    rst_n = 1;
    sweep();

    // R2 R8: store waiting for data at address 1
    alloc_op(1, 0, 0);          sweep();
    // R9: ready store at 2
    alloc_op(2, 1, 16'h0022);   sweep();
    // R10: younger ready store at 1 overrides older waiting one
    alloc_op(1, 1, 16'h0011);   sweep();
    // R3: fill, then try to allocate while full
    alloc_op(3, 0, 0);          sweep();
    alloc_op(0, 1, 16'h00AA);   sweep();
    probe_chk(0);               // R3: rejected store invisible

    // R5: oldest store has no data, commit ignored
    commit_op();                sweep();
    // R4: write to a ready slot has no effect
    wr_op(2, 16'h0099);         sweep();
    // R4: write to waiting slot 0
    wr_op(0, 16'h0010);         sweep();
    commit_op(); commit_op(); commit_op(); sweep();
    commit_op();                sweep();   // R5: slot 3 still waiting

    // R6: hold drain without ready
    @(negedge clk); #1;
    chk("R6 drain offered", drain_valid, 1);
    chk("R6 drain first addr", drain_addr, 1);
    @(negedge clk); #1;
    chk("R6 drain held", drain_valid, 1);
    chk("R6 drain stable addr", drain_addr, 1);
    chk("R6 drain stable data", drain_data, 16'h0010);
    drain_op();                 sweep();

    // R11: same-cycle allocation not seen by probe
    @(negedge clk);
    probe_valid = 1; probe_addr = 5;
    alloc_valid = 1; alloc_addr = 5; alloc_has_data = 1; alloc_data = 16'h0055;
    #1 chk("R11 probe ignores same-cycle alloc", probe_outcome, 0);
    @(posedge clk);
    mst[mtail] = 2; maddr[mtail] = 5; mdata[mtail] = 16'h0055; mtail = (mtail + 1) % D; mcnt++;
    #1 alloc_valid = 0; probe_valid = 0;
    sweep();
    // R11: same-cycle data write not seen by probe (slot 3 waiting at addr 3)
    @(negedge clk);
    probe_valid = 1; probe_addr = 3;
    wdata_valid = 1; wdata_slot = 3; wdata_value = 16'h0033;
    #1 chk("R11 probe ignores same-cycle write", probe_outcome, 1);
    @(posedge clk);
    mst[3] = 2; mdata[3] = 16'h0033;
    #1 wdata_valid = 0; probe_valid = 0;
    sweep();

    // near-exhaustive mixed sequence over a small address space
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 5);
      case (op)
        0: alloc_op(int'($urandom % 4), int'($urandom % 2), int'($urandom % 65536));
        1: wr_op(int'($urandom % D), int'($urandom % 65536));
        2: commit_op();
        3: drain_op();
        default: ;
      endcase
      probe_chk(int'($urandom % 5));
      @(negedge clk); #1; status_chk();
    end
    // empty out
    for (int n = 0; n < D; n++) wr_op(n, 16'h7000 + n);
    for (int n = 0; n < D; n++) begin commit_op(); drain_op(); end
    sweep();
    chk("R6 final empty", empty, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule